// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Lockable Lower Half

This block is a slave on a two-wire serial bus that fronts a 256-byte store held in registers. A master reaches the store with a device type of 1010 in the select byte. It can write bytes after setting the address and read bytes back in sequence. A read can start from the current address pointer. It can also be a random read, where a repeated START follows a dummy address write. The three strap inputs pick which of eight select codes the device answers.

A second device type, 0110, opens a protection command channel. It can lock the lower half of the store (addresses 00h to 7Fh) in a reversible way, or in a permanent way. The reversible set and clear commands are taken only while the high-voltage detect flag is raised. The permanent lock is held in a sticky register. No later command clears it, and power-on reset does not clear it either. A write to a locked byte is still acknowledged, but the stored value stays the same.

SCL and SDA each have an input and an open-drain drive enable; an enable of 1 pulls the line low. Both lines are sampled by the system clock through a synchronizer. The bus must therefore run several system clocks per bus phase.

Top module: `spd_eeprom`

## Requirements
- R1: The device acknowledges a select byte only if its bits 7..4 are 1010 and bits 3..1 equal strap_a[2:0]. Bit 0 is R/W, with 1 meaning read. If the straps do not match, the slave never drives SDA, and a data byte that follows does not reach the store.
- R2: After a write select, the first byte the slave receives sets the address pointer. Each later byte is stored at the pointer, and the pointer then advances by one.
- R3: The pointer advances by one after every byte read or written, and wraps from FFh to 00h.
- R4: A read select returns the byte at the current pointer, so it continues where the last transfer stopped. A repeated START after an address write gives a random read.
- R5: The slave drives an ACK (SDA low) in the ninth clock after every byte it accepts. In a read, a NoAck from the master ends the transfer, and SDA is released.
- R6: The protection channel is a select byte with 0110 in bits 7..4 and R/W = 0. In bits 3..1, code 001 sets the reversible lock, 011 clears it, and 000 sets the permanent lock. Other codes, and R/W = 1, are not acknowledged.
- R7: The set (001) and clear (011) commands are acknowledged and applied only while hv_det is 1. Otherwise they get NoAck and the lock state does not change.
- R8: While either lock is set, a write to 00h–7Fh is acknowledged but leaves the byte unchanged. Addresses 80h–FFh stay writable.
- R9: Once the permanent lock is set, the clear command is refused with NoAck, and the lower half stays locked, including across a power-on reset.
- R10: While por is 1, the slave answers no transfer. Releasing por leaves the bus logic idle with the pointer at 00h. Stored bytes and lock state survive.
- R11: Between power-on resets, the SDA drive changes only after a falling SCL edge, a START or a STOP. scl_oe is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| por | input | 1 | Power-on reset, active high, asynchronous |
| scl_i | input | 1 | Level seen on the SCL line |
| sda_i | input | 1 | Level seen on the SDA line |
| scl_oe | output | 1 | SCL pull-down enable, held at 0 |
| sda_oe | output | 1 | SDA pull-down enable, 1 drives the line low |
| strap_a | input | 3 | Strap levels compared with select bits 3..1 |
| hv_det | input | 1 | High-voltage detect flag shared with strap A0 |

## Verification
A wrong address pointer shows up as the wrong byte on the very next read, or as a write that lands at the wrong place. Readback makes this visible within one transfer. A lock flag in the wrong state shows as a byte that did or did not change after a write to the lower half. It also shows as an ACK or NoAck that differs from the expected one on the next protection command. A slip in the bit counter or the phase machine moves the ACK away from the ninth clock. It also leaves SDA held low at a STOP or START, which the master sees within one byte.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam logic [3:0] DT_MEM = 4'b1010;
  localparam logic [3:0] DT_WP  = 4'b0110;
  localparam logic [2:0] WP_SET  = 3'b001;
  localparam logic [2:0] WP_CLR  = 3'b011;
  localparam logic [2:0] WP_PERM = 3'b000;

  typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_MACK} phase_t;
  typedef enum logic [1:0] {RX_SEL, RX_ADDR, RX_DATA} rx_t;
  typedef enum logic [1:0] {NX_IDLE, NX_ADDR, NX_DATA, NX_TX} next_t;
  typedef enum logic [2:0] {SEL_NONE, SEL_MEM_W, SEL_MEM_R,
                            SEL_WP_SET, SEL_WP_CLR, SEL_WP_PERM} sel_t;

  // Classify a received select byte against the straps.
  function automatic sel_t decode_sel(input logic [7:0] b, input logic [2:0] strap);
    sel_t r;
    r = SEL_NONE;
    if (b[7:4] == DT_MEM && b[3:1] == strap)
      r = b[0] ? SEL_MEM_R : SEL_MEM_W;
    else if (b[7:4] == DT_WP && !b[0]) begin
      case (b[3:1])
        WP_SET:  r = SEL_WP_SET;
        WP_CLR:  r = SEL_WP_CLR;
        WP_PERM: r = SEL_WP_PERM;
        default: r = SEL_NONE;
      endcase
    end
    return r;
  endfunction

  function automatic logic is_wp(input sel_t s);
    return (s == SEL_WP_SET) || (s == SEL_WP_CLR) || (s == SEL_WP_PERM);
  endfunction

  // True when the address lies in the protectable lower half.
  function automatic logic in_lower_half(input logic [15:0] a, input int unsigned aw);
    return (a >> (aw - 1)) == 16'd0;
  endfunction
endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/spd_wp_ctrl.sv
module spd_wp_ctrl
  import spd_pkg::*;
(
  input  logic clk,
  input  logic cmd_valid,
  input  sel_t cmd,
  input  logic hv_det,
  output logic accept,
  output logic rev_lock,
  output logic perm_lock
);
  // Lock state is non-volatile: power-on reset leaves it alone.
  logic rev_q  = 1'b0;
  logic perm_q = 1'b0;

  always_comb begin
    case (cmd)
      SEL_WP_SET, SEL_WP_CLR: accept = hv_det & ~perm_q;
      SEL_WP_PERM:            accept = 1'b1;
      default:                accept = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (cmd_valid && accept) begin
      case (cmd)
        SEL_WP_SET:  rev_q  <= 1'b1;
        SEL_WP_CLR:  rev_q  <= 1'b0;
        SEL_WP_PERM: perm_q <= 1'b1;
        default:     rev_q  <= rev_q;
      endcase
    end
  end

  assign rev_lock  = rev_q;
  assign perm_lock = perm_q;
endmodule

// File: rtl/spd_store.sv
module spd_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/spd_eeprom.sv
module spd_eeprom
  import spd_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [2:0] strap_a,
  input  logic       hv_det
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  phase_t phase_q;
  rx_t    kind_q;
  next_t  next_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, rdata;
  logic [ADDR_W-1:0] ptr_q;
  logic ack_q, mnack_q, sda_oe_q;

  // Named internal events
  logic eval_now, wp_cmd, wp_accept, rev_lock, perm_lock, locked;
  logic wr_req, mem_we, ptr_inc, tx_done, ack_dec;
  sel_t sel;
  next_t next_dec;

  spd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por(por), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  assign sel      = decode_sel(sh_q, strap_a);
  assign eval_now = scl_fall && (phase_q == PH_RX) && (cnt_q == CNT_W'(BYTE_W));
  assign wp_cmd   = eval_now && (kind_q == RX_SEL) && is_wp(sel);

  spd_wp_ctrl u_wp (
    .clk(clk), .cmd_valid(wp_cmd), .cmd(sel), .hv_det(hv_det),
    .accept(wp_accept), .rev_lock(rev_lock), .perm_lock(perm_lock));

  assign locked  = rev_lock | perm_lock;
  assign wr_req  = eval_now && (kind_q == RX_DATA);
  assign mem_we  = wr_req && !(locked && in_lower_half(16'(ptr_q), ADDR_W));
  assign tx_done = (phase_q == PH_TX) && scl_fall && (cnt_q == CNT_W'(BYTE_W - 1));
  assign ptr_inc = wr_req || tx_done;

  spd_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
    .clk(clk), .we(mem_we), .addr(ptr_q), .wdata(sh_q), .rdata(rdata));

  always_comb begin
    ack_dec  = 1'b1;
    next_dec = NX_DATA;
    if (kind_q == RX_SEL) begin
      case (sel)
        SEL_MEM_W: next_dec = NX_ADDR;
        SEL_MEM_R: next_dec = NX_TX;
        SEL_NONE:  begin ack_dec = 1'b0; next_dec = NX_IDLE; end
        default:   begin ack_dec = wp_accept; next_dec = NX_IDLE; end
      endcase
    end
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      phase_q  <= PH_IDLE;
      kind_q   <= RX_SEL;
      next_q   <= NX_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      ptr_q    <= '0;
      ack_q    <= 1'b0;
      mnack_q  <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (start_evt) begin
      phase_q  <= PH_RX;
      kind_q   <= RX_SEL;
      cnt_q    <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_evt) begin
      phase_q  <= PH_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_RX: begin
          if (scl_rise && cnt_q < CNT_W'(BYTE_W)) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end
          if (eval_now) begin
            ack_q    <= ack_dec;
            sda_oe_q <= ack_dec;
            next_q   <= next_dec;
            phase_q  <= PH_ACK;
            if (kind_q == RX_ADDR) ptr_q <= sh_q[ADDR_W-1:0];
            if (kind_q == RX_DATA) ptr_q <= ptr_q + 1'b1;
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            sda_oe_q <= 1'b0;
            cnt_q    <= '0;
            if (!ack_q || next_q == NX_IDLE) phase_q <= PH_IDLE;
            else if (next_q == NX_TX) begin
              phase_q  <= PH_TX;
              sh_q     <= rdata;
              sda_oe_q <= ~rdata[BYTE_W-1];
            end else begin
              phase_q <= PH_RX;
              kind_q  <= (next_q == NX_ADDR) ? RX_ADDR : RX_DATA;
            end
          end
        end
        PH_TX: begin
          if (tx_done) begin
            phase_q  <= PH_MACK;
            sda_oe_q <= 1'b0;
            ptr_q    <= ptr_q + 1'b1;
          end else if (scl_fall) begin
            sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
            cnt_q    <= cnt_q + 1'b1;
            sda_oe_q <= ~sh_q[BYTE_W-2];
          end
        end
        PH_MACK: begin
          if (scl_rise) mnack_q <= sda_s;
          if (scl_fall) begin
            if (mnack_q) phase_q <= PH_IDLE;
            else begin
              phase_q  <= PH_TX;
              cnt_q    <= '0;
              sh_q     <= rdata;
              sda_oe_q <= ~rdata[BYTE_W-1];
            end
          end
        end
        default: sda_oe_q <= 1'b0;
      endcase
    end
  end

  assign sda_oe = sda_oe_q;
  assign scl_oe = 1'b0;
endmodule

// File: rtl/spd_checks.sv
module spd_checks #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              por,
  input logic              sda_oe,
  input logic              scl_oe,
  input logic              hv_det,
  input logic              scl_fall,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              mem_we,
  input logic              ptr_inc,
  input logic [ADDR_W-1:0] ptr_q,
  input logic              rev_lock,
  input logic              perm_lock
);
  assert_quiet_in_por_R10: assert property (@(posedge clk) por |-> !sda_oe);

  assert_perm_sticky_R9: assert property (@(posedge clk) disable iff (por)
    !$fell(perm_lock));

  assert_lock_guard_R8: assert property (@(posedge clk) disable iff (por)
    mem_we |-> !((rev_lock || perm_lock) && !ptr_q[ADDR_W-1]));

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (por)
    ptr_inc |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1));

  assert_hv_gate_R7: assert property (@(posedge clk) disable iff (por)
    !hv_det |=> $stable(rev_lock));

  assert_sda_edge_R11: assert property (@(posedge clk) disable iff (por)
    (!scl_fall && !start_evt && !stop_evt) |=> $stable(sda_oe));

  assert_scl_free_R11: assert property (@(posedge clk) !scl_oe);
endmodule

bind spd_eeprom spd_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .por(por), .sda_oe(sda_oe), .scl_oe(scl_oe), .hv_det(hv_det),
  .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
  .mem_we(mem_we), .ptr_inc(ptr_inc), .ptr_q(ptr_q),
  .rev_lock(rev_lock), .perm_lock(perm_lock));

// File: tb/sim_spd_eeprom.sv
module sim_spd_eeprom;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic hv = 1'b0;
  logic scl_oe, sda_oe;
  logic sda_bus;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  spd_eeprom u0 (
    .clk(clk), .por(por), .scl_i(scl_m), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .strap_a(STRAP), .hv_det(hv));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw; repeat (Q) @(negedge clk); endtask

  task automatic bstart;
    sda_m = 1'b1; qw; scl_m = 1'b1; qw; sda_m = 1'b0; qw; scl_m = 1'b0; qw;
  endtask

  task automatic bstop;
    sda_m = 1'b0; qw; scl_m = 1'b1; qw; sda_m = 1'b1; qw; qw;
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw; scl_m = 1'b1; qw; qw; scl_m = 1'b0; qw;
    end
    sda_m = 1'b1; qw; scl_m = 1'b1; qw; ack = ~sda_bus; qw; scl_m = 1'b0; qw;
  endtask

  task automatic recv(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw; scl_m = 1'b1; qw; b[i] = sda_bus; qw; scl_m = 1'b0;
    end
    qw; sda_m = ~mack; qw; scl_m = 1'b1; qw; qw; scl_m = 1'b0; qw; sda_m = 1'b1;
  endtask

  function automatic logic [7:0] sel_byte(input logic [3:0] dt, input logic [2:0] f, input logic rw);
    return {dt, f, rw};
  endfunction

  task automatic write_at(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1,
                          input int n, input string tag);
    logic ack;
    bstart;
    send(sel_byte(4'b1010, STRAP, 1'b0), ack); chk(ack, {tag, " sel ack R5"}, ack, 1);
    send(a, ack);  chk(ack, {tag, " addr ack R5"}, ack, 1);
    send(d0, ack); chk(ack, {tag, " data ack R5"}, ack, 1);
    if (n > 1) begin send(d1, ack); chk(ack, {tag, " data2 ack R5"}, ack, 1); end
    bstop;
  endtask

  task automatic read_at(input logic [7:0] a, input logic [7:0] e0, input logic [7:0] e1,
                         input int n, input string tag);
    logic ack;
    logic [7:0] b;
    bstart;
    send(sel_byte(4'b1010, STRAP, 1'b0), ack);
    send(a, ack);
    bstart;
    send(sel_byte(4'b1010, STRAP, 1'b1), ack); chk(ack, {tag, " rsel ack R4"}, ack, 1);
    recv(n > 1, b); chk(b == e0, tag, b, e0);
    if (n > 1) begin recv(1'b0, b); chk(b == e1, tag, b, e1); end
    chk(!sda_oe, {tag, " release after NoAck R5"}, sda_oe, 0);
    bstop;
  endtask

  task automatic read_cur(input logic [7:0] e, input string tag);
    logic ack;
    logic [7:0] b;
    bstart;
    send(sel_byte(4'b1010, STRAP, 1'b1), ack); chk(ack, {tag, " ack"}, ack, 1);
    recv(1'b0, b); chk(b == e, tag, b, e);
    bstop;
  endtask

  task automatic wp_cmd(input logic [2:0] code, input logic rw, input logic exp_ack, input string tag);
    logic ack;
    bstart;
    send(sel_byte(4'b0110, code, rw), ack); chk(ack == exp_ack, tag, ack, exp_ack);
    bstop;
  endtask

  task automatic t_reset;
    chk(!sda_oe, "R10 sda idle in por", sda_oe, 0);
    chk(!scl_oe, "R11 scl never driven", scl_oe, 0);
  endtask

  task automatic t_select;
    logic ack;
    bstart; send(sel_byte(4'b1010, STRAP, 1'b0), ack); bstop;
    chk(ack, "R1 matching select acked", ack, 1);
    bstart; send(sel_byte(4'b1010, 3'b011, 1'b0), ack); bstop;
    chk(!ack, "R1 strap mismatch ignored", ack, 0);
  endtask

  task automatic t_write_read;
    write_at(8'h10, 8'hA5, 8'h3C, 2, "R2 write pair");
    write_at(8'h12, 8'h5E, 8'h00, 1, "R2 write single");
    read_at(8'h10, 8'hA5, 8'h3C, 2, "R4 random read R3 seq");
    read_cur(8'h5E, "R4 current read");
  endtask

  task automatic t_wrap;
    write_at(8'hFF, 8'h11, 8'h22, 2, "R3 wrap write");
    read_at(8'hFF, 8'h11, 8'h22, 2, "R3 wrap read");
  endtask

  task automatic t_ignored;
    logic ack;
    bstart;
    send(sel_byte(4'b1010, 3'b000, 1'b0), ack); chk(!ack, "R1 foreign select nack", ack, 0);
    send(8'h10, ack); send(8'hEE, ack);
    bstop;
    read_at(8'h10, 8'hA5, 8'h00, 1, "R1 foreign write left store");
  endtask

  task automatic t_reversible;
    hv = 1'b0;
    wp_cmd(3'b001, 1'b0, 1'b0, "R7 set without hv nack");
    write_at(8'h05, 8'h66, 8'h00, 1, "R7 still writable");
    read_at(8'h05, 8'h66, 8'h00, 1, "R7 unlocked readback");
    hv = 1'b1;
    wp_cmd(3'b001, 1'b1, 1'b0, "R6 read on protect channel nack");
    wp_cmd(3'b101, 1'b0, 1'b0, "R6 unknown code nack");
    wp_cmd(3'b001, 1'b0, 1'b1, "R6 set acked");
    hv = 1'b0;
    write_at(8'h05, 8'h99, 8'h00, 1, "R8 locked write acked");
    read_at(8'h05, 8'h66, 8'h00, 1, "R8 locked byte kept");
    write_at(8'h90, 8'h44, 8'h00, 1, "R8 upper write");
    read_at(8'h90, 8'h44, 8'h00, 1, "R8 upper half writable");
    wp_cmd(3'b011, 1'b0, 1'b0, "R7 clear without hv nack");
    write_at(8'h05, 8'h12, 8'h00, 1, "R7 write while locked");
    read_at(8'h05, 8'h66, 8'h00, 1, "R7 lock kept");
    hv = 1'b1;
    wp_cmd(3'b011, 1'b0, 1'b1, "R6 clear acked");
    hv = 1'b0;
    write_at(8'h05, 8'h12, 8'h00, 1, "R6 write after clear");
    read_at(8'h05, 8'h12, 8'h00, 1, "R6 unlocked again");
  endtask

  task automatic t_por;
    logic ack;
    read_at(8'h40, 8'h00, 8'h00, 0, "R10 move pointer");
    por = 1'b1; qw;
    bstart; send(sel_byte(4'b1010, STRAP, 1'b0), ack); bstop;
    chk(!ack, "R10 no answer in por", ack, 0);
    por = 1'b0; qw;
    read_cur(8'h22, "R10 pointer back to 00");
  endtask

  task automatic t_permanent;
    hv = 1'b0;
    wp_cmd(3'b000, 1'b0, 1'b1, "R6 permanent acked");
    write_at(8'h05, 8'h55, 8'h00, 1, "R9 write under perm");
    read_at(8'h05, 8'h12, 8'h00, 1, "R9 perm blocks write");
    hv = 1'b1;
    wp_cmd(3'b011, 1'b0, 1'b0, "R9 clear refused");
    hv = 1'b0;
    por = 1'b1; qw; por = 1'b0; qw;
    write_at(8'h05, 8'h55, 8'h00, 1, "R9 write after por");
    read_at(8'h05, 8'h12, 8'h00, 1, "R9 lock survives por");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    por = 1'b0; qw;
    t_select;
    t_write_read;
    t_wrap;
    t_ignored;
    t_reversible;
    t_por;
    t_permanent;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule